// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two operands and folds the double-width product into an accumulator held as two registers, HI (upper half) and LO (lower half). One start strobe launches one operation. A 4-bit code picks the arithmetic (plain product, negated product, accumulate-add or accumulate-subtract), the signedness of the operands, and which half of the new accumulator is returned as the result word.

Both halves are written together on the edge that ends an operation. The result word and a one-cycle valid pulse appear on that same edge. Separate write ports load HI and LO directly so the accumulator can be seeded, and the current HI and LO are always visible on read ports. The operand width is a parameter. A second parameter picks how the multiplier is built: one wide multiply, or four half-width partial products with a sign correction.

Top module: `hilo_mac`

## Requirements
- R1: A synchronous reset clears HI, LO and the valid flag to zero.
- R2: The accumulator is {HI, LO}. When start is low, a direct write enable loads its half from the matching data port on the next edge, and hi_out/lo_out always show the stored halves.
- R3: Op bit 3 = 1 treats both operands as two's-complement and sign-extends them to double width. Op bit 3 = 0 zero-extends them.
- R4: Op bits 1:0 = 00 (plain multiply) loads the product into {HI, LO} and always returns the new HI, whatever op bit 2 holds.
- R5: Op bits 1:0 = 01 loads zero minus the product and ignores the earlier accumulator contents.
- R6: Op bits 1:0 = 10 loads {HI, LO} plus the product, wrapping modulo 2^(2*DW).
- R7: Op bits 1:0 = 11 loads {HI, LO} minus the product, wrapping modulo 2^(2*DW).
- R8: For codes 01, 10 and 11, op bit 2 = 1 returns the new HI and op bit 2 = 0 returns the new LO. Both halves are updated in every case.
- R9: result_valid is high for exactly the one cycle after each cycle with start high. HI and LO change only on that edge or through a direct write.
- R10: When start is high, a direct write in the same cycle is ignored.
- R11: Starts on consecutive cycles chain, so each operation uses the accumulator left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch one operation |
| op | input | 4 | Operation code: bit 3 signed, bit 2 return HI, bits 1:0 function |
| opa | input | DW | First operand |
| opb | input | DW | Second operand |
| hi_wr_en | input | 1 | Direct load of HI |
| hi_wr_data | input | DW | Data for the direct HI load |
| lo_wr_en | input | 1 | Direct load of LO |
| lo_wr_data | input | DW | Data for the direct LO load |
| result | output | DW | Selected half of the new accumulator |
| result_valid | output | 1 | One-cycle pulse marking result |
| hi_out | output | DW | Current HI |
| lo_out | output | DW | Current LO |

## Verification
The bench builds the unit with DW = 32 and SPLIT_MUL = 1. This routes every product through the four partial products and the two-term sign correction. With these values, the operand extremes (all ones, the most negative value, and mixed signs) reach the cross terms where a wrong shift or a missing correction would appear. Full-width wraparound in the add and subtract paths is also reached from accumulators seeded through the direct write ports.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  // function selected by op[1:0]
  typedef enum logic [1:0] {
    FN_MUL  = 2'b00,
    FN_NMUL = 2'b01,
    FN_MADD = 2'b10,
    FN_MSUB = 2'b11
  } mac_fn_e;

  // op[3] signed, op[2] return HI, op[1:0] function
  typedef struct packed {
    logic    is_signed;
    logic    want_hi;
    mac_fn_e fn;
  } mac_op_t;

endpackage

// File: rtl/hilo_mac_mult.sv
module hilo_mac_mult #(
  parameter int DW        = 32,
  parameter bit SPLIT_MUL = 1'b1
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            is_signed,
  output logic [2*DW-1:0] prod
);
  localparam int PW = 2 * DW;
  localparam int HW = DW / 2;
  localparam int HU = DW - HW;

  logic [PW-1:0] raw;

  // signed product = unsigned product minus the weight of each sign bit
  function automatic logic [PW-1:0] sign_fix(input logic [PW-1:0] u,
                                             input logic [DW-1:0] x,
                                             input logic [DW-1:0] y);
    logic [PW-1:0] cx, cy;
    cx = x[DW-1] ? {y, {DW{1'b0}}} : '0;
    cy = y[DW-1] ? {x, {DW{1'b0}}} : '0;
    return u - cx - cy;
  endfunction

  generate
    if (SPLIT_MUL) begin : g_split
      logic [PW-1:0] al, ah, bl, bh;
      logic [PW-1:0] p_ll, p_lh, p_hl, p_hh;
      assign al   = {{(PW-HW){1'b0}}, a[HW-1:0]};
      assign ah   = {{(PW-HU){1'b0}}, a[DW-1:HW]};
      assign bl   = {{(PW-HW){1'b0}}, b[HW-1:0]};
      assign bh   = {{(PW-HU){1'b0}}, b[DW-1:HW]};
      assign p_ll = al * bl;
      assign p_lh = al * bh;
      assign p_hl = ah * bl;
      assign p_hh = ah * bh;
      assign raw  = p_ll + (p_lh << HW) + (p_hl << HW) + (p_hh << (2 * HW));
    end else begin : g_wide
      assign raw = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    end
  endgenerate

  assign prod = is_signed ? sign_fix(raw, a, b) : raw;

endmodule

// File: rtl/hilo_mac_combine.sv
module hilo_mac_combine
  import hilo_mac_pkg::*;
#(
  parameter int PW = 64
) (
  input  mac_fn_e       fn,
  input  logic [PW-1:0] acc,
  input  logic [PW-1:0] prod,
  output logic [PW-1:0] nxt
);

  function automatic logic [PW-1:0] merge(input mac_fn_e f,
                                          input logic [PW-1:0] s,
                                          input logic [PW-1:0] p);
    case (f)
      FN_MUL:  return p;
      FN_NMUL: return '0 - p;
      FN_MADD: return s + p;
      default: return s - p;
    endcase
  endfunction

  assign nxt = merge(fn, acc, prod);

endmodule

// File: rtl/hilo_mac_acc.sv
module hilo_mac_acc #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [2*DW-1:0] nxt,
  input  logic            hi_we,
  input  logic [DW-1:0]   hi_wd,
  input  logic            lo_we,
  input  logic [DW-1:0]   lo_wd,
  output logic [DW-1:0]   hi_q,
  output logic [DW-1:0]   lo_q
);
  localparam int NH = 2;

  logic          we [NH];
  logic [DW-1:0] wd [NH];
  logic [DW-1:0] q  [NH];

  assign we[0] = lo_we;
  assign wd[0] = lo_wd;
  assign we[1] = hi_we;
  assign wd[1] = hi_wd;

  generate
    for (genvar h = 0; h < NH; h++) begin : g_half
      always_ff @(posedge clk) begin
        if (rst)         q[h] <= '0;
        else if (load)   q[h] <= nxt[h*DW +: DW];
        else if (we[h])  q[h] <= wd[h];
      end
    end
  endgenerate

  assign lo_q = q[0];
  assign hi_q = q[1];

endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_mac_pkg::*;
#(
  parameter int DW        = 32,
  parameter bit SPLIT_MUL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          hi_wr_en,
  input  logic [DW-1:0] hi_wr_data,
  input  logic          lo_wr_en,
  input  logic [DW-1:0] lo_wr_data,
  output logic [DW-1:0] result,
  output logic          result_valid,
  output logic [DW-1:0] hi_out,
  output logic [DW-1:0] lo_out
);
  localparam int PW = 2 * DW;

  mac_op_t       dec;
  logic [PW-1:0] prod;
  logic [PW-1:0] acc_now;
  logic [PW-1:0] acc_next;
  logic          res_from_hi;
  logic [DW-1:0] res_next;
  logic [DW-1:0] result_q;
  logic          valid_q;

  assign dec     = mac_op_t'(op);
  assign acc_now = {hi_out, lo_out};

  hilo_mac_mult #(.DW(DW), .SPLIT_MUL(SPLIT_MUL)) u_mult (
    .a(opa), .b(opb), .is_signed(dec.is_signed), .prod(prod)
  );

  hilo_mac_combine #(.PW(PW)) u_comb (
    .fn(dec.fn), .acc(acc_now), .prod(prod), .nxt(acc_next)
  );

  hilo_mac_acc #(.DW(DW)) u_acc (
    .clk(clk), .rst(rst), .load(start), .nxt(acc_next),
    .hi_we(hi_wr_en), .hi_wd(hi_wr_data),
    .lo_we(lo_wr_en), .lo_wd(lo_wr_data),
    .hi_q(hi_out), .lo_q(lo_out)
  );

  // plain multiply always hands back HI
  assign res_from_hi = dec.want_hi || (dec.fn == FN_MUL);
  assign res_next    = res_from_hi ? acc_next[PW-1:DW] : acc_next[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= start;
      if (start) result_q <= res_next;
    end
  end

  assign result       = result_q;
  assign result_valid = valid_q;

endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [3:0]    op,
  input logic          hi_wr_en,
  input logic          lo_wr_en,
  input logic [DW-1:0] result,
  input logic          result_valid,
  input logic [DW-1:0] hi_out,
  input logic [DW-1:0] lo_out
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (hi_out == '0 && lo_out == '0 && !result_valid)); // R1

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> result_valid); // R9

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    !start |=> !result_valid); // R9

  AST_HI_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!start && !hi_wr_en) |=> $stable(hi_out)); // R9

  AST_LO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!start && !lo_wr_en) |=> $stable(lo_out)); // R9

  AST_RESULT_IS_HI: assert property (@(posedge clk) disable iff (rst)
    (result_valid && ($past(op[2]) || $past(op[1:0]) == 2'b00)) |-> result == hi_out); // R8

  AST_RESULT_IS_LO: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !$past(op[2]) && $past(op[1:0]) != 2'b00) |-> result == lo_out); // R8

endmodule

bind hilo_mac hilo_mac_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op),
  .hi_wr_en(hi_wr_en), .lo_wr_en(lo_wr_en),
  .result(result), .result_valid(result_valid),
  .hi_out(hi_out), .lo_out(lo_out)
);

// File: tb/hilo_mac_test.sv
`timescale 1ns/1ps
module hilo_mac_test;
  localparam int DW = 32;

  typedef struct packed {
    logic [3:0]    op;
    logic [DW-1:0] res;
    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [3:0]    op = '0;
  logic [DW-1:0] opa = '0, opb = '0;
  logic          hi_wr_en = 1'b0, lo_wr_en = 1'b0;
  logic [DW-1:0] hi_wr_data = '0, lo_wr_data = '0;
  logic [DW-1:0] result, hi_out, lo_out;
  logic          result_valid;

  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  logic [63:0] model = '0;

  always #4 clk = ~clk;

  hilo_mac #(.DW(DW), .SPLIT_MUL(1'b1)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .result(result), .result_valid(result_valid),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] o);
    case (o[1:0])
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  // product as the requirements state it: extend, then multiply
  function automatic logic [63:0] ref_prod(logic s, logic [31:0] a, logic [31:0] b);
    longint sa, sb2;
    logic [63:0] ua, ub;
    if (s) begin
      sa  = longint'($signed(a));
      sb2 = longint'($signed(b));
      return 64'(sa * sb2);
    end
    ua = {32'b0, a};
    ub = {32'b0, b};
    return ua * ub;
  endfunction

  // driver: one start pulse; collide also drives both direct writes (R10)
  task automatic do_op(logic [3:0] o, logic [31:0] a, logic [31:0] b, bit collide = 0);
    logic [63:0] p;
    exp_t e;
    p = ref_prod(o[3], a, b);
    case (o[1:0])
      2'b00:   model = p;
      2'b01:   model = 64'd0 - p;
      2'b10:   model = model + p;
      default: model = model - p;
    endcase
    e.op  = o;
    e.hi  = model[63:32];
    e.lo  = model[31:0];
    e.res = (o[2] || o[1:0] == 2'b00) ? model[63:32] : model[31:0];
    sb.push_back(e);
    op = o; opa = a; opb = b; start = 1'b1;
    hi_wr_en = collide; lo_wr_en = collide;
    hi_wr_data = 32'hDEAD_BEEF; lo_wr_data = 32'hFEED_F00D;
    @(posedge clk); #1;
    start = 1'b0; hi_wr_en = 1'b0; lo_wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: pop and compare on every valid pulse
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && result_valid) begin
        if (sb.size() == 0) begin
          check("R9 unexpected valid", 64'd1, 64'd0);
        end else begin
          e = sb.pop_front();
          check({tag_of(e.op), " R8 R3 result"}, {32'b0, result}, {32'b0, e.res});
          check({tag_of(e.op), " R11 hilo"}, {hi_out, lo_out}, {e.hi, e.lo});
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    @(negedge clk);
    check("R1 reset hilo", {hi_out, lo_out}, 64'd0);
    check("R1 reset valid", {63'd0, result_valid}, 64'd0);

    // R2: seed the accumulator
    @(posedge clk); #1;
    hi_wr_en = 1'b1; hi_wr_data = 32'h1234_5678;
    lo_wr_en = 1'b1; lo_wr_data = 32'h9ABC_DEF0;
    @(posedge clk); #1;
    hi_wr_en = 1'b0; lo_wr_en = 1'b0;
    @(negedge clk);
    check("R2 direct write", {hi_out, lo_out}, 64'h1234_5678_9ABC_DEF0);
    model = 64'h1234_5678_9ABC_DEF0;
    @(posedge clk); #1;
    lo_wr_en = 1'b1; lo_wr_data = 32'h0000_0001;
    @(posedge clk); #1;
    lo_wr_en = 1'b0;
    @(negedge clk);
    check("R2 LO only", {hi_out, lo_out}, 64'h1234_5678_0000_0001);
    model = 64'h1234_5678_0000_0001;
    idle(1);

    do_op(4'b0010, 32'd3, 32'd5);                  // R6 unsigned, LO
    idle(2);
    do_op(4'b1110, 32'hFFFF_FFFF, 32'd7);          // R6 signed, HI
    idle(2);
    do_op(4'b1011, 32'h8000_0000, 32'h8000_0000); // R7 signed, LO
    idle(2);
    do_op(4'b0111, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R7 unsigned, HI
    idle(2);
    do_op(4'b1001, 32'hFFFF_FFFF, 32'd2);          // R5 signed, LO
    idle(2);
    do_op(4'b0101, 32'hFFFF_FFFF, 32'd2);          // R5 unsigned, HI
    idle(2);
    do_op(4'b1000, 32'hFFFF_FFFE, 32'd3);          // R4 signed, bit2=0 still HI
    idle(2);
    do_op(4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R4 R3 unsigned extremes
    idle(2);
    do_op(4'b1100, 32'h7FFF_FFFF, 32'h8000_0000); // R4 R3 signed mixed
    idle(2);
    do_op(4'b1010, 32'd100, 32'hFFFF_FFF6, 1);     // R10 collision ignored
    idle(2);
    // R11: back-to-back chain
    do_op(4'b0010, 32'h0001_0000, 32'h0001_0000);
    do_op(4'b0011, 32'd9, 32'd9);
    do_op(4'b1110, 32'hFFFF_0000, 32'h0000_FFFF);
    do_op(4'b0110, 32'd1, 32'd1);
    idle(3);

    for (int i = 0; i < 300; i++) begin
      do_op(4'($urandom), $urandom, $urandom, ($urandom % 5) == 0);
      if (($urandom % 3) == 0) idle(1);
    end
    idle(4);
    check("R9 queue drained", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule